// File: doc/BRIEF.md
# Switch Connection Request Transmit Controller

This controller sits in the transmit path of a serial backplane transceiver, between user packet FIFOs and the link to a crossbar switch. It reads tagged words from the head of a FIFO. Each word carries a 2-bit type. When it reads a connection-request word, it sends that word towards the switch and then waits for the switch's acknowledge. While it waits, data words of the packet already in flight keep moving. This lets arbitration for the next packet overlap the tail of the current one.

If the header of the next packet reaches the FIFO head before the grant, the controller stops reading, raises a stall flag and sends the stored request again on every cycle. A request or null word loaded while waiting replaces the pending request. An abort input drops the request. After the grant, four response bits arrive serially, one per cycle, and are gathered for queue-selection logic. An optional programmable delay gives that logic time to act before the header and data are read.

Top module: `crq_tx_ctrl`

## Requirements
- R1: Word types are 0 data, 1 header, 2 connection request, 3 null request. With no request pending, a type-2 word at the FIFO head is read at once and appears on the link output one cycle later. No further read happens in that next cycle, and the request is not sent again unless R3 applies.
- R2: Every word read from the FIFO appears on the link output exactly once, one cycle after its read, in FIFO order. Data words (type 0) are read while the grant is awaited.
- R3: If a header (type 1) is at the FIFO head while the grant is awaited, it is not read. The stall output rises the next cycle, and from the cycle after that the stored request word is sent on every cycle until the grant or abort.
- R4: A type-2 word read while the grant is awaited replaces the stored request, and later replays send the new word. A type-3 word read while waiting is forwarded and ends the wait, so a word behind it is read in the following cycle.
- R5: Abort while the grant is awaited, or while replaying, returns the block to idle. The stall output is low the next cycle, no request word follows, and a header at the FIFO head stays unread.
- R6: A grant with the delay enable low lets the FIFO read enable go high in the cycle after the grant.
- R7: A grant with the delay enable high holds reads off for N cycles, so the read enable first goes high N+1 cycles after the grant cycle. N resets to 6.
- R8: A configuration write sets N. With N = 0, a delayed grant behaves like an undelayed one.
- R9: Response bit P0 is sampled in the cycle after the grant, and P1 to P3 in the following cycles. The collected value {P3,P2,P1,P0} is presented with a one-cycle valid pulse in the cycle after P3.
- R10: After a replay, the stall output falls in the same cycle that the read enable rises.
- R11: In idle, data and header words are not read and nothing is sent. The read enable is never high without a valid FIFO word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | FIFO head word present |
| in_type_i | input | 2 | Type tag of the head word |
| in_word_i | input | 32 | Head word |
| rd_en_o | output | 1 | Pops the FIFO head this cycle |
| ack_i | input | 1 | Grant from the switch |
| resp_i | input | 1 | Serial response bit, P0 first |
| abort_i | input | 1 | Drops the pending request |
| dly_en_i | input | 1 | Enables the post-grant delay |
| cfg_we_i | input | 1 | Writes the delay length |
| cfg_dly_i | input | 4 | New delay length N |
| tx_valid_o | output | 1 | Link word valid |
| tx_type_o | output | 2 | Link word type |
| tx_word_o | output | 32 | Link word |
| stall_o | output | 1 | Reads held off by a replayed request |
| prio_o | output | 4 | Collected response bits {P3,P2,P1,P0} |
| prio_vld_o | output | 1 | One-cycle pulse when prio_o is new |

## Verification
The main path is tried with four patterns. The first sends a request followed by data, with the grant arriving together with the next header; it separates the undelayed grant from a replay. The second sends the next header early with the delay enabled, so the replay count, the stall edge and the N-cycle hold can be told apart. The third replaces a pending request and then aborts it, which shows whether replays carry the old word or the new one and whether abort clears the stall. The fourth cancels with a null word and programs N = 0, separating a cancelled wait and a zero delay from the default timing.

// File: rtl/crq_tx_pkg.sv
package crq_tx_pkg;
  typedef enum logic [1:0] {
    WT_DATA = 2'd0,
    WT_HDR  = 2'd1,
    WT_CRQ  = 2'd2,
    WT_NULL = 2'd3
  } wtype_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SEND_CRQ   = 3'd1,
    ST_WAIT_ACK   = 3'd2,
    ST_REPEAT_CRQ = 3'd3,
    ST_COLLECT_P  = 3'd4,
    ST_DELAY      = 3'd5,
    ST_STREAM     = 3'd6
  } state_e;
endpackage

// File: rtl/crq_tx_fsm.sv
module crq_tx_fsm
  import crq_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] type_i,
  input  logic       ack_i,
  input  logic       abort_i,
  input  logic       dly_en_i,
  input  logic       dly_zero_i,
  input  logic       dly_last_i,
  input  logic       resp_busy_i,
  output state_e     state_o,
  output logic       rd_en_o,
  output logic       grant_o,
  output logic       dly_start_o,
  output logic       stall_o
);
  state_e state_q, state_d;
  logic   rpt_q;

  always_comb begin
    state_d = state_q;
    rd_en_o = 1'b0;
    grant_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (valid_i && (type_i == WT_CRQ || type_i == WT_NULL)) begin
          rd_en_o = 1'b1;
          if (type_i == WT_CRQ) state_d = ST_SEND_CRQ;
        end
      end
      ST_SEND_CRQ: state_d = ST_WAIT_ACK;
      ST_WAIT_ACK, ST_REPEAT_CRQ: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else if (ack_i) begin
          grant_o = 1'b1;
          state_d = (dly_en_i && !dly_zero_i) ? ST_COLLECT_P : ST_STREAM;
        end else if (state_q == ST_WAIT_ACK && valid_i) begin
          unique case (type_i)
            WT_HDR:  state_d = ST_REPEAT_CRQ;
            WT_CRQ:  begin rd_en_o = 1'b1; state_d = ST_SEND_CRQ; end
            WT_NULL: begin rd_en_o = 1'b1; state_d = ST_STREAM;   end
            default: rd_en_o = 1'b1;
          endcase
        end
      end
      ST_COLLECT_P: begin
        if (dly_last_i)        state_d = ST_STREAM;
        else if (!resp_busy_i) state_d = ST_DELAY;
      end
      ST_DELAY: if (dly_last_i) state_d = ST_STREAM;
      ST_STREAM: begin
        if (valid_i) begin
          rd_en_o = 1'b1;
          if (type_i == WT_CRQ) state_d = ST_SEND_CRQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rpt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REPEAT_CRQ)
        rpt_q <= 1'b1;
      else if (state_q != ST_COLLECT_P && state_q != ST_DELAY)
        rpt_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign dly_start_o = grant_o && dly_en_i;
  assign stall_o     = (state_q == ST_REPEAT_CRQ) ||
                       (rpt_q && (state_q == ST_COLLECT_P || state_q == ST_DELAY));
endmodule

// File: rtl/crq_tx_delay.sv
module crq_tx_delay #(
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned DLY_RST = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  input  logic             start_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [DLY_W-1:0] n_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= DLY_W'(DLY_RST);
      cnt_q <= '0;
    end else begin
      if (cfg_we_i) n_q <= cfg_dly_i;
      if (start_i)          cnt_q <= n_q;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (n_q == '0);
  assign last_o = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/crq_tx_resp.sv
module crq_tx_resp #(
  parameter int unsigned NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_i,
  output logic [NB-1:0] bits_o,
  output logic          vld_o,
  output logic          busy_o
);
  localparam int unsigned CW = $clog2(NB + 1);
  logic [CW-1:0] cnt_q;
  logic [NB-1:0] sh_q;
  logic          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(NB);
      vld_q <= 1'b0;
    end else if (cnt_q != '0) begin
      // first bit ends up in bit 0
      if (NB > 1) sh_q <= {bit_i, sh_q[NB-1:1]};
      else        sh_q <= bit_i;
      cnt_q <= cnt_q - 1'b1;
      vld_q <= (cnt_q == CW'(1));
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign bits_o = sh_q;
  assign vld_o  = vld_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/crq_tx_ctrl.sv
module crq_tx_ctrl
  import crq_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned DLY_RST = 6,
  parameter int unsigned NB      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        in_type_i,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              rd_en_o,
  input  logic              ack_i,
  input  logic              resp_i,
  input  logic              abort_i,
  input  logic              dly_en_i,
  input  logic              cfg_we_i,
  input  logic [DLY_W-1:0]  cfg_dly_i,
  output logic              tx_valid_o,
  output logic [1:0]        tx_type_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              stall_o,
  output logic [NB-1:0]     prio_o,
  output logic              prio_vld_o
);
  state_e state;
  logic   grant, dly_start, dly_zero, dly_last, resp_busy;
  logic   rd_en;
  logic [WORD_W-1:0] crq_q;

  crq_tx_fsm u_fsm (
    .clk_i, .rst_ni,
    .valid_i     (in_valid_i),
    .type_i      (in_type_i),
    .ack_i, .abort_i, .dly_en_i,
    .dly_zero_i  (dly_zero),
    .dly_last_i  (dly_last),
    .resp_busy_i (resp_busy),
    .state_o     (state),
    .rd_en_o     (rd_en),
    .grant_o     (grant),
    .dly_start_o (dly_start),
    .stall_o     (stall_o)
  );

  crq_tx_delay #(.DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_dly (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_dly_i,
    .start_i (dly_start),
    .zero_o  (dly_zero),
    .last_o  (dly_last)
  );

  crq_tx_resp #(.NB(NB)) u_resp (
    .clk_i, .rst_ni,
    .start_i (grant),
    .bit_i   (resp_i),
    .bits_o  (prio_o),
    .vld_o   (prio_vld_o),
    .busy_o  (resp_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crq_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_type_o  <= WT_DATA;
      tx_word_o  <= '0;
    end else begin
      if (rd_en && in_type_i == WT_CRQ) crq_q <= in_word_i;
      if (rd_en) begin
        tx_valid_o <= 1'b1;
        tx_type_o  <= in_type_i;
        tx_word_o  <= in_word_i;
      end else if (state == ST_REPEAT_CRQ) begin
        tx_valid_o <= 1'b1;
        tx_type_o  <= WT_CRQ;
        tx_word_o  <= crq_q;
      end else begin
        tx_valid_o <= 1'b0;
        tx_type_o  <= WT_DATA;
        tx_word_o  <= '0;
      end
    end
  end

  assign rd_en_o = rd_en;
endmodule

// File: rtl/crq_tx_ctrl_chk.sv
module crq_tx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_i,
  input logic       in_valid_i,
  input logic       rd_en_o,
  input logic       stall_o,
  input logic       ack_i,
  input logic       abort_i,
  input logic       dly_en_i,
  input logic       tx_valid_o,
  input logic [1:0] tx_type_o,
  input logic       prio_vld_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_WAIT = 3'd2, S_RPT = 3'd3, S_STREAM = 3'd6;

  p_stall_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !rd_en_o);

  p_replay_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_RPT) |=> (tx_valid_o && tx_type_o == 2'd2));

  p_abort_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == S_WAIT || state_i == S_RPT) && abort_i) |=> (state_i == S_IDLE && !stall_o));

  p_grant_nodly_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == S_WAIT || state_i == S_RPT) && ack_i && !abort_i && !dly_en_i)
      |=> (state_i == S_STREAM));

  p_prio_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_vld_o |=> !prio_vld_o);

  p_stall_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stall_o) && state_i == S_STREAM) |-> (rd_en_o || !in_valid_i));

  p_read_needs_word_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> in_valid_i);
endmodule

bind crq_tx_ctrl crq_tx_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state),
  .in_valid_i (in_valid_i),
  .rd_en_o    (rd_en_o),
  .stall_o    (stall_o),
  .ack_i      (ack_i),
  .abort_i    (abort_i),
  .dly_en_i   (dly_en_i),
  .tx_valid_o (tx_valid_o),
  .tx_type_o  (tx_type_o),
  .prio_vld_o (prio_vld_o)
);

// File: tb/crq_tx_ctrl_test.sv
`timescale 1ns/1ps
module crq_tx_ctrl_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_type = 2'd0;
  logic [W-1:0]  in_word = '0;
  logic          rd_en_o;
  logic          ack = 1'b0, resp = 1'b0, abort = 1'b0, dly_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_dly = 4'd0;
  logic          tx_valid_o;
  logic [1:0]    tx_type_o;
  logic [W-1:0]  tx_word_o;
  logic          stall_o;
  logic [3:0]    prio_o;
  logic          prio_vld_o;

  int n_chk = 0, n_fail = 0;
  bit pop_pend = 1'b0;
  logic [W+1:0] fifo[$];
  logic [W+1:0] exp_q[$];
  string        exp_req[$];

  always #4 clk = ~clk;

  crq_tx_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_type_i(in_type), .in_word_i(in_word),
    .rd_en_o(rd_en_o), .ack_i(ack), .resp_i(resp), .abort_i(abort),
    .dly_en_i(dly_en), .cfg_we_i(cfg_we), .cfg_dly_i(cfg_dly),
    .tx_valid_o(tx_valid_o), .tx_type_o(tx_type_o), .tx_word_o(tx_word_o),
    .stall_o(stall_o), .prio_o(prio_o), .prio_vld_o(prio_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fin(input logic [1:0] t, input logic [W-1:0] w);
    fifo.push_back({t, w});
  endtask

  task automatic expect_tx(input logic [1:0] t, input logic [W-1:0] w, input string req);
    exp_q.push_back({t, w});
    exp_req.push_back(req);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // bench FIFO: pop after a read, present head, note read for next edge
  always @(negedge clk) begin
    if (pop_pend) void'(fifo.pop_front());
    #1;
    if (fifo.size() > 0) begin
      in_valid = 1'b1;
      {in_type, in_word} = fifo[0];
    end else begin
      in_valid = 1'b0;
    end
    #1;
    pop_pend = rd_en_o && in_valid;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected link word", {30'd0, tx_type_o, tx_word_o}, 0);
      end else begin
        logic [W+1:0] e;
        string r;
        e = exp_q.pop_front();
        r = exp_req.pop_front();
        chk({tx_type_o, tx_word_o} == e, r, {30'd0, tx_type_o, tx_word_o}, {30'd0, e});
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc(); #3;
    chk(!stall_o, "R11 reset stall", stall_o, 0);
    chk(!tx_valid_o, "R11 reset tx", tx_valid_o, 0);
    chk(!prio_vld_o, "R9 reset prio", prio_vld_o, 0);

    // idle: header must not be read
    cyc(); fin(2'd1, 32'h55);
    cyc(); cyc(); cyc(); #3;
    chk(!rd_en_o, "R11 idle header read", rd_en_o, 0);
    chk(!tx_valid_o, "R11 idle tx", tx_valid_o, 0);
    cyc(); fifo.delete();
    cyc();

    // pattern 1: request, data, grant with header, no delay
    cyc();
    fin(2'd2, 32'hA1); fin(2'd0, 32'h1); fin(2'd0, 32'h2);
    expect_tx(2'd2, 32'hA1, "R1 request sent");
    expect_tx(2'd0, 32'h1, "R2 data while waiting");
    expect_tx(2'd0, 32'h2, "R2 data while waiting");
    expect_tx(2'd1, 32'h100, "R6 header after grant");
    expect_tx(2'd0, 32'h3, "R6 data after grant");
    #3 chk(rd_en_o, "R1 request read", rd_en_o, 1);
    cyc(); #3;
    chk(tx_valid_o && tx_type_o == 2'd2, "R1 request on link", tx_type_o, 2);
    chk(!rd_en_o, "R1 no read while sending", rd_en_o, 0);
    cyc(); cyc(); cyc(); cyc(); #3;
    chk(!tx_valid_o, "R1 no resend", tx_valid_o, 0);
    cyc();
    ack = 1'b1; dly_en = 1'b0;
    fin(2'd1, 32'h100); fin(2'd0, 32'h3);
    #3 chk(!rd_en_o, "R6 no read in grant cycle", rd_en_o, 0);
    cyc(); ack = 1'b0; resp = 1'b1;
    #3 chk(rd_en_o, "R6 read after grant", rd_en_o, 1);
    cyc(); resp = 1'b0;
    cyc(); resp = 1'b1;
    cyc(); resp = 1'b1;
    cyc(); resp = 1'b0; #3;
    chk(prio_vld_o && prio_o == 4'b1101, "R9 response bits", {prio_vld_o, prio_o}, 5'h1D);
    cyc(); #3;
    chk(!prio_vld_o, "R9 single pulse", prio_vld_o, 0);

    // pattern 2: early request, header early, replay, delayed grant
    cyc();
    dly_en = 1'b1;
    fin(2'd2, 32'hB2); fin(2'd0, 32'h4); fin(2'd1, 32'h200); fin(2'd0, 32'h5);
    expect_tx(2'd2, 32'hB2, "R1 early request");
    expect_tx(2'd0, 32'h4, "R2 data while waiting");
    repeat (3) expect_tx(2'd2, 32'hB2, "R3 replayed request");
    expect_tx(2'd1, 32'h200, "R7 header after delay");
    expect_tx(2'd0, 32'h5, "R7 data after delay");
    cyc(); cyc(); cyc();
    cyc(); #3;
    chk(stall_o, "R3 stall on header", stall_o, 1);
    chk(!rd_en_o, "R3 header not read", rd_en_o, 0);
    cyc(); #3;
    chk(tx_valid_o && tx_type_o == 2'd2 && tx_word_o == 32'hB2, "R3 replay word", tx_word_o, 32'hB2);
    cyc(); ack = 1'b1;
    cyc(); ack = 1'b0; resp = 1'b0;
    cyc(); resp = 1'b1;
    cyc(); resp = 1'b1;
    cyc(); resp = 1'b0;
    cyc(); #3;
    chk(prio_vld_o && prio_o == 4'b0110, "R9 response bits", {prio_vld_o, prio_o}, 5'h16);
    cyc(); #3;
    chk(stall_o && !rd_en_o, "R7 held through delay", {stall_o, rd_en_o}, 2'b10);
    cyc(); #3;
    chk(rd_en_o, "R7 read after N cycles", rd_en_o, 1);
    chk(!stall_o, "R10 stall falls with read", stall_o, 0);
    cyc(); cyc(); cyc();

    // pattern 3: replace pending request, then abort
    cyc();
    fin(2'd2, 32'hC3);
    expect_tx(2'd2, 32'hC3, "R4 first request");
    expect_tx(2'd2, 32'hC4, "R4 replacing request");
    repeat (3) expect_tx(2'd2, 32'hC4, "R4 replay carries new word");
    cyc(); cyc(); fin(2'd2, 32'hC4);
    cyc(); cyc(); fin(2'd1, 32'h300);
    cyc(); cyc(); cyc(); abort = 1'b1;
    cyc(); abort = 1'b0; #3;
    chk(!stall_o, "R5 stall cleared by abort", stall_o, 0);
    cyc(); #3;
    chk(!tx_valid_o, "R5 no request after abort", tx_valid_o, 0);
    chk(!rd_en_o, "R5 header stays unread", rd_en_o, 0);
    cyc(); fifo.delete();
    cfg_we = 1'b1; cfg_dly = 4'd0;
    cyc(); cfg_we = 1'b0;

    // pattern 3b: zero delay with delay enabled
    cyc();
    fin(2'd2, 32'hC5);
    expect_tx(2'd2, 32'hC5, "R8 request");
    expect_tx(2'd1, 32'h400, "R8 header with zero delay");
    cyc();
    cyc(); ack = 1'b1; fin(2'd1, 32'h400);
    cyc(); ack = 1'b0; #3;
    chk(rd_en_o, "R8 zero delay reads at once", rd_en_o, 1);
    repeat (6) cyc();

    // pattern 4: null request cancels the wait
    cyc();
    fin(2'd2, 32'hC6);
    expect_tx(2'd2, 32'hC6, "R4 request before null");
    expect_tx(2'd3, 32'h0, "R4 null forwarded");
    expect_tx(2'd0, 32'h6, "R4 data after null");
    cyc(); cyc(); fin(2'd3, 32'h0);
    cyc(); fin(2'd0, 32'h6);
    #3 chk(rd_en_o, "R4 wait ended by null", rd_en_o, 1);
    repeat (4) cyc();
    chk(exp_q.size() == 0, "R2 all words sent", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule